// File: doc/BRIEF.md
# Dual-Port Semaphore Latch Bank

This block holds a small set of hardware semaphores shared by a left and a right port. It is kept apart from any data memory. Each port reaches a semaphore through its own select line and a low-order index taken from its address. A write strobe carries a request or a release on data bit 0, and a read strobe samples who owns that semaphore. Two agents use it to claim a shared resource. An agent writes 0 to ask for the resource and reads back 0 once it holds it. It writes 1 when it is done.

Each semaphore remembers a request from each side. A request that loses to the current owner is not dropped. It waits, and it turns into ownership in the same cycle that the owner releases. A read puts the captured ownership bit on every data line and holds it in a register for each port. A later write from the other side therefore cannot disturb a value that has already been read. The memory enable input is present only so that an access with both enables active can be rejected.

Top module: `sem_bank`

## Requirements
- R1: After reset every semaphore is free with no request waiting, so a read of any index from either port returns all ones.
- R2: The semaphore is picked by the three lowest address bits (index 0 to 7); all higher address bits have no effect.
- R3: On a write only data bit 0 counts: 0 places the port's request, 1 withdraws the port's request or gives up its ownership.
- R4: When a free semaphore is requested by one port, that port reads all zeros (owner) and the other port reads all ones; two same-cycle reads of one index never both return zero.
- R5: A request from the non-owner while the semaphore is held is refused (it reads all ones) but is kept, and it becomes ownership in the cycle the owner writes 1.
- R6: When the owner writes 1 and the other side has no request waiting, the semaphore becomes free and both ports read all ones.
- R7: Only the owner's own release ends its ownership; a 0 written by the owner changes nothing.
- R8: A read captures, at the clock edge of the read strobe, the state as it was before writes in that same cycle, drives it on all data bits, and holds it until that port's next accepted read.
- R9: An access is accepted only when the port's semaphore select is high and its memory enable is low; any other combination leaves semaphore state and the port's read data unchanged.
- R10: If both ports request the same free semaphore in the same cycle, the left port becomes owner and the right request waits.
- R11: A waiting request that its port withdraws by writing 1 before it is granted is dropped, so a later release leaves the semaphore free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| l_sem_sel | input | 1 | Left semaphore select, active high |
| l_mem_en | input | 1 | Left memory enable; high together with select makes the access illegal |
| l_addr | input | 13 | Left address; low three bits pick the semaphore |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_wdata | input | 8 | Left write data; bit 0 used |
| l_rdata | output | 8 | Left captured read data |
| r_sem_sel | input | 1 | Right semaphore select, active high |
| r_mem_en | input | 1 | Right memory enable |
| r_addr | input | 13 | Right address |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_wdata | input | 8 | Right write data; bit 0 used |
| r_rdata | output | 8 | Right captured read data |

## Verification
A read by one port and a write by the other can land on the same semaphore in the same cycle. The bench provokes this by giving the right port ownership of an index with a left request waiting, then issuing the left read and the right release in the same cycle. The left read must return the state from before the release, all ones. A following left read must show the hand-over, all zeros. Simultaneous requests by both ports to one free index are driven the same way, and the bench checks which side wins.

// File: rtl/sem_pkg.sv
`timescale 1ns/1ps
package sem_pkg;

  typedef enum logic [1:0] {
    SEM_FREE  = 2'b00,
    SEM_LEFT  = 2'b01,
    SEM_RIGHT = 2'b10
  } sem_owner_e;

endpackage

// File: rtl/sem_port_dec.sv
`timescale 1ns/1ps
// Turns one port's strobes into per-semaphore request/release pulses.
module sem_port_dec #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              sem_sel,
  input  logic              mem_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_SEM-1:0] req_set,
  output logic [NUM_SEM-1:0] req_clr,
  output logic              rd_fire,
  output logic [IDX_W-1:0]  rd_idx
);

  logic             access_ok;
  logic [IDX_W-1:0] idx;
  logic             unused_bits;

  assign access_ok   = sem_sel & ~mem_en;
  assign idx         = addr[IDX_W-1:0];
  assign rd_fire     = access_ok & rd;
  assign rd_idx      = idx;
  assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_hit
    logic hit;
    assign hit        = access_ok & wr & (idx == IDX_W'(g));
    assign req_set[g] = hit & ~wdata[0];
    assign req_clr[g] = hit &  wdata[0];
  end

endmodule

// File: rtl/sem_cell.sv
`timescale 1ns/1ps
// One semaphore: a waiting-request flag per side plus the current owner.
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_set,
  input  logic l_clr,
  input  logic r_set,
  input  logic r_clr,
  output logic own_l,
  output logic own_r
);

  sem_owner_e owner_q, owner_d;
  logic       req_l_q, req_l_d;
  logic       req_r_q, req_r_d;
  logic       upd_en;

  assign upd_en = l_set | l_clr | r_set | r_clr;

  always_comb begin
    req_l_d = req_l_q;
    if (l_clr)      req_l_d = 1'b0;
    else if (l_set) req_l_d = 1'b1;

    req_r_d = req_r_q;
    if (r_clr)      req_r_d = 1'b0;
    else if (r_set) req_r_d = 1'b1;

    owner_d = owner_q;
    case (owner_q)
      SEM_FREE: begin
        if (req_l_d)      owner_d = SEM_LEFT;
        else if (req_r_d) owner_d = SEM_RIGHT;
      end
      SEM_LEFT: begin
        if (!req_l_d) owner_d = req_r_d ? SEM_RIGHT : SEM_FREE;
      end
      SEM_RIGHT: begin
        if (!req_r_d) owner_d = req_l_d ? SEM_LEFT : SEM_FREE;
      end
      default: owner_d = SEM_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= SEM_FREE;
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
    end else if (upd_en) begin
      owner_q <= owner_d;
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
    end
  end

  assign own_l = (owner_q == SEM_LEFT);
  assign own_r = (owner_q == SEM_RIGHT);

endmodule

// File: rtl/sem_rd_latch.sv
`timescale 1ns/1ps
// Per-port read capture register: 0 on every bit when this port owns.
module sem_rd_latch #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_fire,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic [NUM_SEM-1:0] own_vec,
  output logic [DATA_W-1:0]  rdata
);

  logic              rd_bit;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  always_comb begin
    rd_bit  = ~own_vec[rd_idx];
    rdata_d = {DATA_W{rd_bit}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '1;
    else if (rd_fire) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/sem_bank.sv
`timescale 1ns/1ps
module sem_bank #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sem_sel,
  input  logic              l_mem_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sem_sel,
  input  logic              r_mem_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);

  logic [1:0]         rst_pipe_q;
  logic               rst_core_n;
  logic [NUM_SEM-1:0] l_set, l_clr, r_set, r_clr;
  logic [NUM_SEM-1:0] own_l_vec, own_r_vec;
  logic               l_rd_fire, r_rd_fire;
  logic [IDX_W-1:0]   l_rd_idx, r_rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
    .sem_sel(l_sem_sel), .mem_en(l_mem_en), .addr(l_addr), .wr(l_wr),
    .rd(l_rd), .wdata(l_wdata), .req_set(l_set), .req_clr(l_clr),
    .rd_fire(l_rd_fire), .rd_idx(l_rd_idx));

  sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
    .sem_sel(r_sem_sel), .mem_en(r_mem_en), .addr(r_addr), .wr(r_wr),
    .rd(r_rd), .wdata(r_wdata), .req_set(r_set), .req_clr(r_clr),
    .rd_fire(r_rd_fire), .rd_idx(r_rd_idx));

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
    sem_cell u_cell (
      .clk(clk), .rst_n(rst_core_n),
      .l_set(l_set[g]), .l_clr(l_clr[g]),
      .r_set(r_set[g]), .r_clr(r_clr[g]),
      .own_l(own_l_vec[g]), .own_r(own_r_vec[g]));
  end

  sem_rd_latch #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
    .clk(clk), .rst_n(rst_core_n), .rd_fire(l_rd_fire), .rd_idx(l_rd_idx),
    .own_vec(own_l_vec), .rdata(l_rdata));

  sem_rd_latch #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
    .clk(clk), .rst_n(rst_core_n), .rd_fire(r_rd_fire), .rd_idx(r_rd_idx),
    .own_vec(own_r_vec), .rdata(r_rdata));

endmodule

// File: rtl/sem_bank_chk.sv
`timescale 1ns/1ps
module sem_bank_chk #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              l_sem_sel,
  input logic              l_mem_en,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_wr,
  input logic              l_rd,
  input logic [DATA_W-1:0] l_wdata,
  input logic [DATA_W-1:0] l_rdata,
  input logic              r_sem_sel,
  input logic              r_mem_en,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_wr,
  input logic              r_rd,
  input logic [DATA_W-1:0] r_wdata,
  input logic [DATA_W-1:0] r_rdata,
  input logic [NUM_SEM-1:0] own_l_vec,
  input logic [NUM_SEM-1:0] own_r_vec
);

  logic l_ok, r_ok;
  assign l_ok = l_sem_sel & ~l_mem_en;
  assign r_ok = r_sem_sel & ~r_mem_en;

  assert_rdata_uniform_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

  assert_l_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(l_ok && l_rd) |=> $stable(l_rdata));

  assert_r_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(r_ok && r_rd) |=> $stable(r_rdata));

  assert_no_dual_owner_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (l_ok && l_rd && r_ok && r_rd && l_addr[IDX_W-1:0] == r_addr[IDX_W-1:0])
    |=> !(l_rdata[0] == 1'b0 && r_rdata[0] == 1'b0));

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem
    assert_l_only_owner_releases_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
      $fell(own_l_vec[g]) |-> $past(l_ok && l_wr && l_wdata[0] &&
                                    l_addr[IDX_W-1:0] == IDX_W'(g)));
    assert_r_only_owner_releases_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
      $fell(own_r_vec[g]) |-> $past(r_ok && r_wr && r_wdata[0] &&
                                    r_addr[IDX_W-1:0] == IDX_W'(g)));
    assert_left_wins_tie_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
      (!own_l_vec[g] && !own_r_vec[g] &&
       l_ok && l_wr && !l_wdata[0] && l_addr[IDX_W-1:0] == IDX_W'(g) &&
       r_ok && r_wr && !r_wdata[0] && r_addr[IDX_W-1:0] == IDX_W'(g))
      |=> own_l_vec[g]);
  end

endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_sem_bank.sv
`timescale 1ns/1ps
module tb_sem_bank;

  logic        clk;
  logic        rst_n;
  logic        l_sem_sel, l_mem_en, l_wr, l_rd;
  logic [12:0] l_addr;
  logic [7:0]  l_wdata, l_rdata;
  logic        r_sem_sel, r_mem_en, r_wr, r_rd;
  logic [12:0] r_addr;
  logic [7:0]  r_wdata, r_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  sem_bank dut (
    .clk(clk), .rst_n(rst_n),
    .l_sem_sel(l_sem_sel), .l_mem_en(l_mem_en), .l_addr(l_addr), .l_wr(l_wr),
    .l_rd(l_rd), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sem_sel(r_sem_sel), .r_mem_en(r_mem_en), .r_addr(r_addr), .r_wr(r_wr),
    .r_rd(r_rd), .r_wdata(r_wdata), .r_rdata(r_rdata));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic idle();
    l_sem_sel = 0; l_mem_en = 0; l_addr = '0; l_wr = 0; l_rd = 0; l_wdata = '0;
    r_sem_sel = 0; r_mem_en = 0; r_addr = '0; r_wr = 0; r_rd = 0; r_wdata = '0;
  endtask

  task automatic set_l(input logic sel, mem, input logic [12:0] a,
                       input logic wr, rd, input logic [7:0] wd);
    l_sem_sel = sel; l_mem_en = mem; l_addr = a; l_wr = wr; l_rd = rd; l_wdata = wd;
  endtask

  task automatic set_r(input logic sel, mem, input logic [12:0] a,
                       input logic wr, rd, input logic [7:0] wd);
    r_sem_sel = sel; r_mem_en = mem; r_addr = a; r_wr = wr; r_rd = rd; r_wdata = wd;
  endtask

  // Inputs are set just after a falling edge; one rising edge takes them.
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic expect8(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic lw(input logic [12:0] a, input logic [7:0] wd);
    set_l(1, 0, a, 1, 0, wd); step();
  endtask

  task automatic rw(input logic [12:0] a, input logic [7:0] wd);
    set_r(1, 0, a, 1, 0, wd); step();
  endtask

  task automatic read_both(input string req, input logic [12:0] la, input logic [12:0] ra,
                           input logic [7:0] exp_l, input logic [7:0] exp_r);
    set_l(1, 0, la, 0, 1, 8'h00);
    set_r(1, 0, ra, 0, 1, 8'h00);
    step();
    expect8(req, "left read", l_rdata, exp_l);
    expect8(req, "right read", r_rdata, exp_r);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) read_both("R1", 13'(i), 13'(i), 8'hFF, 8'hFF);
  endtask

  task automatic t_acquire_queue();
    lw(13'd3, 8'hFE);                              // R3: bit0 = 0 requests
    read_both("R4", 13'd3, 13'd3, 8'h00, 8'hFF);
    rw(13'd3, 8'h00);                              // right request refused
    read_both("R5", 13'd3, 13'd3, 8'h00, 8'hFF);
    lw(13'd3, 8'h00);                              // owner writes 0 again
    read_both("R7", 13'd3, 13'd3, 8'h00, 8'hFF);
    lw(13'd3, 8'hF1);                              // R3: bit0 = 1 releases
    read_both("R5", 13'd3, 13'd3, 8'hFF, 8'h00);
    rw(13'd3, 8'h01);
    read_both("R6", 13'd3, 13'd3, 8'hFF, 8'hFF);
  endtask

  task automatic t_tie();
    set_l(1, 0, 13'd5, 1, 0, 8'h00);
    set_r(1, 0, 13'd5, 1, 0, 8'h00);
    step();
    read_both("R10", 13'd5, 13'd5, 8'h00, 8'hFF);
    lw(13'd5, 8'h01);
    read_both("R10", 13'd5, 13'd5, 8'hFF, 8'h00);
    rw(13'd5, 8'h01);
    read_both("R6", 13'd5, 13'd5, 8'hFF, 8'hFF);
  endtask

  task automatic t_withdraw();
    lw(13'd2, 8'h00);
    rw(13'd2, 8'h00);
    rw(13'd2, 8'h01);                              // withdraw while waiting
    lw(13'd2, 8'h01);
    read_both("R11", 13'd2, 13'd2, 8'hFF, 8'hFF);
  endtask

  task automatic t_high_addr();
    lw(13'h1FF9, 8'h00);                           // index 1
    read_both("R2", 13'h0001, 13'h0A49, 8'h00, 8'hFF);
    read_both("R2", 13'h1001, 13'h0001, 8'h00, 8'hFF);
    lw(13'h0409, 8'h01);
    read_both("R2", 13'h0001, 13'h0001, 8'hFF, 8'hFF);
  endtask

  task automatic t_illegal();
    set_l(1, 1, 13'd4, 1, 0, 8'h00); step();       // both enables: ignored
    read_both("R9", 13'd4, 13'd4, 8'hFF, 8'hFF);
    set_l(0, 0, 13'd4, 1, 0, 8'h00); step();       // no select: ignored
    read_both("R9", 13'd4, 13'd4, 8'hFF, 8'hFF);
    lw(13'd4, 8'h00);
    read_both("R9", 13'd4, 13'd4, 8'h00, 8'hFF);
    lw(13'd4, 8'h01);
    set_l(1, 1, 13'd4, 0, 1, 8'h00); step();       // illegal read: hold
    expect8("R9", "illegal read keeps data", l_rdata, 8'h00);
    set_l(0, 0, 13'd4, 0, 1, 8'h00); step();       // unselected read: hold
    expect8("R9", "unselected read keeps data", l_rdata, 8'h00);
  endtask

  task automatic t_read_vs_write();
    rw(13'd6, 8'h00);
    lw(13'd6, 8'h00);                              // left waits
    set_l(1, 0, 13'd6, 0, 1, 8'h00);
    set_r(1, 0, 13'd6, 1, 0, 8'h01);               // release in the same cycle
    step();
    expect8("R8", "read beside release", l_rdata, 8'hFF);
    read_both("R8", 13'd6, 13'd6, 8'h00, 8'hFF);
    lw(13'd6, 8'h01);
    step();
    expect8("R8", "held after state change", l_rdata, 8'h00);
    read_both("R8", 13'd6, 13'd6, 8'hFF, 8'hFF);
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_acquire_queue();
    t_tie();
    t_withdraw();
    t_high_addr();
    t_illegal();
    t_read_vs_write();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule